// File: doc/BRIEF.md
# Trap-Entry State Controller

This block updates a processor's trap-control and privilege-control registers. It acts when a trap is taken or when a power-on reset is signalled. For each accepted event it samples the current trap level, global level, processor-state word and hyper-state word, and works out the privilege level the core is running at. It then selects one of four actions:

- power-on initialisation;
- reset-state trap entry;
- error-state signalling;
- ordinary trap entry.

All new register values from one event are written together on a single clock edge. A one-cycle completion pulse is raised with them, along with a code that tells the fetch logic which vector group to use. Computing the handler address belongs to a neighbouring block.

The register outputs hold their last written values between events, so a surrounding register file can copy them when the completion pulse is seen.

Top module: `trap_entry_ctl`

## Requirements
- R1: Privilege is decoded from processor-state bit 2 and hyper-state bit 2. If the processor-state bit is clear, the level is user. If the processor-state bit is set and the hyper-state bit is clear, the level is privileged. If both bits are set, the level is hyperprivileged. An ordinary trap taken from user or privileged level enters privileged level. An ordinary trap taken from hyperprivileged level does not.
- R2: A trap request takes the reset-state path when hyper-state bit 5 is already set, or when the current trap level equals MAX_TL-1. On this path `vecSel` is 5.
- R3: A trap request at a trap level of MAX_TL or above writes no register output. On this path `errState` and `done` pulse together and `vecSel` is 0.
- R4: The reset-state path writes the hyper-state input with bits 5 and 2 set and all other bits kept.
- R5: The reset-state path writes the global level as the smaller of the current global level plus one and MAX_GL.
- R6: The reset-state path rewrites the processor-state input as follows. Bit 4 is set. Bits 9, 3, 2 and 1 are cleared. Every other bit, including bit 8, is kept.
- R7: An ordinary trap into privileged level sets processor-state bit 2 and copies bit 8 into bit 9. Any other ordinary trap clears bits 2 and 9. In both cases bit 1 is cleared and the remaining bits are kept.
- R8: An ordinary trap writes the trap level as the current level plus one, and latches the trap type. It passes the global level and the hyper-state through unchanged. `vecSel` is 0.
- R9: A power-on reset makes these writes:
  - trap level = MAX_TL, global level = MAX_GL;
  - processor-state = 0x10;
  - hyper-state = input with bits 5 and 2 set and bits 10 and 0 cleared;
  - trap type = 1, tick = only bit 63 set;
  - `vecSel` = 1.
- R10: A power-on reset in the same cycle as a trap request is handled as a power-on reset only.
- R11: After reset all outputs are 0. Every accepted event produces exactly one `done` pulse one cycle later, with all of its register writes visible in that same cycle. `done` is low in cycles with no event.
- R12: The reset-state path writes the trap level as the current level plus one, saturating at MAX_TL, and latches the trap type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request strobe |
| trapType | input | TT_W | Trap type code of the request |
| porReq | input | 1 | Power-on reset strobe |
| curTl | input | TL_W | Current trap level |
| curGl | input | GL_W | Current global level |
| curPstate | input | 64 | Current processor-state word |
| curHpstate | input | 64 | Current hyper-state word |
| done | output | 1 | One-cycle completion pulse |
| errState | output | 1 | Error-state flag, raised with `done` |
| vecSel | output | 3 | Vector group select: 0 none, 1 power-on, 5 reset-state |
| tlOut | output | TL_W | Written trap level |
| glOut | output | GL_W | Written global level |
| pstateOut | output | 64 | Written processor-state word |
| hpstateOut | output | 64 | Written hyper-state word |
| ttOut | output | TT_W | Written trap type |
| tickOut | output | 64 | Written tick register |

## Verification
The embedded properties assume that requests are low while reset is asserted. They also assume that the global-level input never exceeds MAX_GL, so a saturated write is always in range. The stimulus changes inputs only on falling edges and holds requests low during reset. It uses only trap and global levels within their encodable ranges. It still reaches the edge values MAX_TL-1, MAX_TL and MAX_TL+1, and a global level already at MAX_GL.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef struct packed {
    logic por;
    logic red;
    logic norm;
    logic err;
    logic toPriv;
  } entryStrobe_t;

  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;
  localparam int HS_TLZ  = 0;
  localparam int HS_HPRIV = 2;
  localparam int HS_RED  = 5;
  localparam int HS_IBE  = 10;

  localparam logic [2:0] VEC_NONE = 3'd0;
  localparam logic [2:0] VEC_POR  = 3'd1;
  localparam logic [2:0] VEC_RED  = 3'd5;

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int TL_W = $clog2(MAX_TL + 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic            porReq,
  input  logic [TL_W-1:0] curTl,
  input  logic            psPriv,
  input  logic            hsPriv,
  input  logic            hsRed,
  output entryStrobe_t    st,
  output logic            done,
  output logic            errState,
  output logic [2:0]      vecSel
);

  localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_EDGE = TL_W'(MAX_TL - 1);

  logic isHyper;
  logic redCond;

  always_comb begin
    isHyper   = psPriv && hsPriv;
    redCond   = hsRed || (curTl == TL_EDGE);
    st        = '0;
    st.toPriv = !isHyper;
    if (porReq) begin
      st.por = 1'b1;
    end else if (trapReq) begin
      if (redCond)              st.red  = 1'b1;
      else if (curTl >= TL_TOP) st.err  = 1'b1;
      else                      st.norm = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      errState <= 1'b0;
      vecSel   <= VEC_NONE;
    end else begin
      done     <= st.por | st.red | st.norm | st.err;
      errState <= st.err;
      vecSel   <= st.por ? VEC_POR : (st.red ? VEC_RED : VEC_NONE);
    end
  end

  assert_err_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    errState |-> (done && vecSel == VEC_NONE));

  assert_red_vec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (vecSel == VEC_RED) |-> (done && !errState));

  assert_por_prio_R10: assert property (@(posedge clk) disable iff (!rstN)
    (porReq && trapReq) |=> (vecSel == VEC_POR && !errState));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!porReq && !trapReq) |=> !done);

endmodule

// File: rtl/trap_entry_datapath.sv
module trap_entry_datapath
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int TT_W   = 9,
  parameter int POR_TT = 1,
  parameter int TL_W   = $clog2(MAX_TL + 2),
  parameter int GL_W   = $clog2(MAX_GL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  entryStrobe_t    st,
  input  logic [TT_W-1:0] trapType,
  input  logic [TL_W-1:0] curTl,
  input  logic [GL_W-1:0] curGl,
  input  logic [63:0]     curPs,
  input  logic [63:0]     curHs,
  output logic [TL_W-1:0] tlOut,
  output logic [GL_W-1:0] glOut,
  output logic [63:0]     pstateOut,
  output logic [63:0]     hpstateOut,
  output logic [TT_W-1:0] ttOut,
  output logic [63:0]     tickOut
);

  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);
  localparam logic [GL_W-1:0] GL_TOP = GL_W'(MAX_GL);

  logic [TL_W-1:0] tlInc;
  logic [GL_W-1:0] glSat;
  logic [63:0]     psRed, psNorm, psPor, hsRed, hsPor;

  always_comb begin
    tlInc = (curTl >= TL_TOP) ? TL_TOP : curTl + TL_W'(1);
    glSat = (curGl >= GL_TOP) ? GL_TOP : curGl + GL_W'(1);

    psRed         = curPs;
    psRed[PS_PEF] = 1'b1;
    psRed[PS_AM]  = 1'b0;
    psRed[PS_PRIV] = 1'b0;
    psRed[PS_IE]  = 1'b0;
    psRed[PS_CLE] = 1'b0;

    psNorm = curPs;
    if (st.toPriv) begin
      psNorm[PS_PRIV] = 1'b1;
      psNorm[PS_CLE]  = curPs[PS_TLE];
    end else begin
      psNorm[PS_PRIV] = 1'b0;
      psNorm[PS_CLE]  = 1'b0;
    end
    psNorm[PS_IE] = 1'b0;

    psPor         = '0;
    psPor[PS_PEF] = 1'b1;

    hsRed           = curHs;
    hsRed[HS_RED]   = 1'b1;
    hsRed[HS_HPRIV] = 1'b1;

    hsPor         = hsRed;
    hsPor[HS_IBE] = 1'b0;
    hsPor[HS_TLZ] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlOut      <= '0;
      glOut      <= '0;
      pstateOut  <= '0;
      hpstateOut <= '0;
      ttOut      <= '0;
      tickOut    <= '0;
    end else if (st.por) begin
      tlOut      <= TL_TOP;
      glOut      <= GL_TOP;
      pstateOut  <= psPor;
      hpstateOut <= hsPor;
      ttOut      <= TT_W'(POR_TT);
      tickOut    <= 64'h8000_0000_0000_0000;
    end else if (st.red) begin
      tlOut      <= tlInc;
      glOut      <= glSat;
      pstateOut  <= psRed;
      hpstateOut <= hsRed;
      ttOut      <= trapType;
    end else if (st.norm) begin
      tlOut      <= tlInc;
      glOut      <= curGl;
      pstateOut  <= psNorm;
      hpstateOut <= curHs;
      ttOut      <= trapType;
    end
  end

  assert_por_values_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.por)) |->
      (tlOut == TL_TOP && glOut == GL_TOP && pstateOut == 64'h10 && tickOut[63]
       && hpstateOut[HS_RED] && !hpstateOut[HS_IBE] && !hpstateOut[HS_TLZ]));

  assert_red_hs_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.red)) |-> (hpstateOut[HS_RED] && hpstateOut[HS_HPRIV]));

  assert_gl_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.red)) |-> (glOut <= GL_TOP));

  assert_red_ps_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.red)) |-> (pstateOut[PS_PEF] && !pstateOut[PS_PRIV] && !pstateOut[PS_CLE]));

  assert_norm_ie_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.norm)) |-> !pstateOut[PS_IE]);

  assert_err_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.err)) |-> ($stable(tlOut) && $stable(pstateOut) && $stable(hpstateOut)));

endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int TT_W   = 9,
  parameter int POR_TT = 1,
  localparam int TL_W  = $clog2(MAX_TL + 2),
  localparam int GL_W  = $clog2(MAX_GL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  input  logic            porReq,
  input  logic [TL_W-1:0] curTl,
  input  logic [GL_W-1:0] curGl,
  input  logic [63:0]     curPstate,
  input  logic [63:0]     curHpstate,
  output logic            done,
  output logic            errState,
  output logic [2:0]      vecSel,
  output logic [TL_W-1:0] tlOut,
  output logic [GL_W-1:0] glOut,
  output logic [63:0]     pstateOut,
  output logic [63:0]     hpstateOut,
  output logic [TT_W-1:0] ttOut,
  output logic [63:0]     tickOut
);

  entryStrobe_t st;

  trap_entry_ctrl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .porReq(porReq), .curTl(curTl),
    .psPriv(curPstate[PS_PRIV]), .hsPriv(curHpstate[HS_HPRIV]), .hsRed(curHpstate[HS_RED]),
    .st(st), .done(done), .errState(errState), .vecSel(vecSel)
  );

  trap_entry_datapath #(
    .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .TT_W(TT_W), .POR_TT(POR_TT), .TL_W(TL_W), .GL_W(GL_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .trapType(trapType), .curTl(curTl), .curGl(curGl),
    .curPs(curPstate), .curHs(curHpstate), .tlOut(tlOut), .glOut(glOut),
    .pstateOut(pstateOut), .hpstateOut(hpstateOut), .ttOut(ttOut), .tickOut(tickOut)
  );

endmodule

// File: tb/sim_trap_entry_ctl.sv
module sim_trap_entry_ctl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [8:0]  trapType = '0;
  logic        porReq = 1'b0;
  logic [2:0]  curTl = '0;
  logic [1:0]  curGl = '0;
  logic [63:0] curPstate = '0;
  logic [63:0] curHpstate = '0;
  logic        done, errState;
  logic [2:0]  vecSel;
  logic [2:0]  tlOut;
  logic [1:0]  glOut;
  logic [63:0] pstateOut, hpstateOut, tickOut;
  logic [8:0]  ttOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  typedef struct {
    logic [2:0]  tl;
    logic [1:0]  gl;
    logic [63:0] ps;
    logic [63:0] hs;
    logic [8:0]  tt;
    logic [63:0] tick;
    logic [2:0]  vec;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  expItem_t m;

  trap_entry_ctl u0 (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType), .porReq(porReq),
    .curTl(curTl), .curGl(curGl), .curPstate(curPstate), .curHpstate(curHpstate),
    .done(done), .errState(errState), .vecSel(vecSel), .tlOut(tlOut), .glOut(glOut),
    .pstateOut(pstateOut), .hpstateOut(hpstateOut), .ttOut(ttOut), .tickOut(tickOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // Monitor: pops an expected item whenever the design reports completion.
  always @(negedge clk) begin
    if (rstN && done) begin
      checks++;
      if (sbQ.size() == 0) begin
        failures++;
        $display("FAIL R11 done with no pending event");
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        if (tlOut !== e.tl || glOut !== e.gl || pstateOut !== e.ps || hpstateOut !== e.hs ||
            ttOut !== e.tt || tickOut !== e.tick || vecSel !== e.vec || errState !== e.err) begin
          failures++;
          $display("FAIL %s act tl=%0d gl=%0d ps=%h hs=%h tt=%0d tick=%h vec=%0d err=%b exp tl=%0d gl=%0d ps=%h hs=%h tt=%0d tick=%h vec=%0d err=%b",
            e.tag, tlOut, glOut, pstateOut, hpstateOut, ttOut, tickOut, vecSel, errState,
            e.tl, e.gl, e.ps, e.hs, e.tt, e.tick, e.vec, e.err);
        end
      end
    end
  end

  task automatic fire(input logic por, input logic trap, input logic [8:0] tt,
                      input logic [2:0] tl, input logic [1:0] gl,
                      input logic [63:0] ps, input logic [63:0] hs, input string tag);
    expItem_t e;
    logic toPriv;
    @(negedge clk);
    porReq = por; trapReq = trap; trapType = tt;
    curTl = tl; curGl = gl; curPstate = ps; curHpstate = hs;
    e = m; e.tag = tag; e.err = 1'b0; e.vec = 3'd0;
    if (por) begin
      e.tl = 3'd6; e.gl = 2'd3; e.ps = 64'h10;
      e.hs = (hs | 64'h24) & ~64'h401;
      e.tt = 9'd1; e.tick = 64'h8000_0000_0000_0000; e.vec = 3'd1;
    end else if (hs[5] || tl == 3'd5) begin
      e.tl = (tl >= 3'd6) ? 3'd6 : tl + 3'd1;
      e.gl = (gl >= 2'd3) ? 2'd3 : gl + 2'd1;
      e.ps = (ps | 64'h10) & ~64'h20E;
      e.hs = hs | 64'h24;
      e.tt = tt; e.vec = 3'd5;
    end else if (tl >= 3'd6) begin
      e.err = 1'b1;
    end else begin
      toPriv = !(ps[2] && hs[2]);
      e.ps = ps;
      e.ps[2] = toPriv;
      e.ps[9] = toPriv ? ps[8] : 1'b0;
      e.ps[1] = 1'b0;
      e.tl = tl + 3'd1; e.gl = gl; e.hs = hs; e.tt = tt;
    end
    m = e;
    sbQ.push_back(e);
    @(negedge clk);
    porReq = 1'b0; trapReq = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      failures++;
      $display("FAIL R11 done in idle cycle act=%b exp=0", done);
    end
  endtask

  initial begin
    m = '{tl: 0, gl: 0, ps: 0, hs: 0, tt: 0, tick: 0, vec: 0, err: 0, tag: ""};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 0 || errState !== 0 || vecSel !== 0 || tlOut !== 0 || glOut !== 0 ||
        pstateOut !== 0 || hpstateOut !== 0 || ttOut !== 0 || tickOut !== 0) begin
      failures++;
      $display("FAIL R11 reset state act tl=%0d ps=%h hs=%h tick=%h exp all zero",
               tlOut, pstateOut, hpstateOut, tickOut);
    end
    fire(1, 0, 9'h0,  3'd0, 2'd0, 64'hFFFF, 64'h0000_0000_0000_0C03, "R9 power-on writes");
    fire(1, 1, 9'h41, 3'd2, 2'd1, 64'h0004, 64'h0000_0000_0000_0401, "R10 power-on over trap");
    fire(0, 1, 9'h20, 3'd0, 2'd0, 64'h0000_0000_0000_0102, 64'h0, "R1 R7 user to privileged");
    fire(0, 1, 9'h21, 3'd2, 2'd2, 64'h0000_0000_0000_0206, 64'h0, "R7 privileged tle clear");
    fire(0, 1, 9'h22, 3'd1, 2'd1, 64'h0000_0000_0000_0306, 64'h0000_0000_0000_0004, "R1 hyper stays");
    fire(0, 1, 9'h30, 3'd5, 2'd1, 64'h0000_0000_0000_031E, 64'h0000_0000_0000_0400, "R2 R12 R6 tl edge");
    fire(0, 1, 9'h31, 3'd2, 2'd3, 64'hA000_0000_0000_0106, 64'h0000_0000_0000_0020, "R2 R5 R4 red bit set");
    fire(0, 1, 9'h32, 3'd6, 2'd0, 64'h0000_0000_0000_0004, 64'h0, "R3 error at top level");
    fire(0, 1, 9'h33, 3'd7, 2'd2, 64'h0000_0000_0000_0006, 64'h4, "R3 error above top");
    fire(0, 1, 9'h1FF, 3'd4, 2'd2, 64'h5000_0000_0000_0100, 64'h0000_0000_0000_0001, "R8 normal entry");
    fire(0, 1, 9'h34, 3'd5, 2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0020, "R12 R5 both red causes");
    repeat (2) @(negedge clk);
    checks++;
    if (sbQ.size() != 0) begin
      failures++;
      $display("FAIL R11 missing done pulses act=%0d exp=0", sbQ.size());
    end
    finish_run();
  end

endmodule